// File: doc/BRIEF.md
# Thirty-two line GPIO bank with grouped interrupts

The block is a bank of general-purpose pins behind a small word-wide register bus. Each pin can drive an output value, act as an input, or blink. Input levels are passed through a two-flop synchronizer and then optionally inverted per pin, which gives the visible input word. That one polarity choice sets both the active level and the active edge of the pin's interrupt.

Every pin can raise an interrupt in two ways. The first is a level request that tracks the visible input under a level enable. The second is a sticky edge flag under an edge enable. The edge flag is cleared by software writing zeros. The requests are ORed per bank of eight pins onto four summary lines for an upstream interrupt controller. A free-running divider makes a shared blink phase for pins in blink mode.

Top module: `gpio_irq_bank`

## Requirements
- R1: After a synchronous active-low reset, every readable register except the input word reads 0. Every pin is an output (`pad_oe` all ones) driving 0, and every `irq_bank` line is 0.
- R2: A direction bit of 1 makes the pin an input (`pad_oe` bit 0). A direction bit of 0 makes it an output (`pad_oe` bit 1) that drives its output-value bit on `pad_out` when blink is off.
- R3: Registers sit at these byte addresses: output value 0x00, direction 0x04, blink enable 0x08, polarity 0x0C, input word 0x10 (read-only), edge flags 0x14, edge enable 0x18+MASK_OFS and level enable 0x1C+MASK_OFS. Writes to the input word, to the nominal mask addresses when MASK_OFS is nonzero, or to unmapped addresses change no register. Unmapped reads return 0.
- R4: The input word equals the pad level XOR the polarity bit. A pad change becomes visible after exactly two rising clock edges. A polarity write takes effect at once.
- R5: A pin's level request is its input-word bit AND its level-enable bit. It is not latched and drops as soon as the input word bit falls.
- R6: An edge flag sets on the clock edge after its input-word bit goes from 0 to 1. This is a rising pad edge with polarity 0 and a falling one with polarity 1. The flag stays set until it is cleared, and a 1-to-0 change of the input word does not set it.
- R7: A write to the edge-flag register clears each flag whose data bit is 0 and keeps each flag whose data bit is 1. A flag whose edge arrives in the same cycle as a clearing write ends up set.
- R8: Changing a polarity bit while the pad is steady does not set that pin's edge flag.
- R9: `irq_bank[g]` is the OR, over pins 8g to 8g+7, of (level request) OR (edge flag AND edge enable).
- R10: A pin with blink enable set drives the shared blink phase instead of its output value. The phase toggles every BLINK_DIV clock cycles, counted from reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Read data for `bus_addr`, combinational |
| pad_in | input | NPINS | Asynchronous pad levels |
| pad_out | output | NPINS | Value to drive on each pad |
| pad_oe | output | NPINS | 1 where the pad is driven (direction bit 0) |
| irq_bank | output | NPINS/GROUP_W | One summary interrupt per bank of eight pins |

## Verification
The assertions check, on every cycle, these rules: an edge flag never drops except on a write to its register; configuration registers hold when there is no write; any enabled level or edge request shows up on some summary line; and the blink phase changes only on the divider boundary. The bench sweeps every pin, with both polarities. It shows things that need stimulus and timing: the two-cycle synchronizer latency, which pad edge sets a flag, a polarity change that leaves the flag clear, set winning over a concurrent clear, bank routing of each pin, and address decoding with a nonzero mask offset.

// File: rtl/gpio_bank_pkg.sv
// Package: register byte offsets shared by the GPIO bank and its checker.
// Assumes word-aligned byte addresses; the two mask offsets get the
// MASK_OFS parameter added at the point of use.
package gpio_bank_pkg;
    localparam int OFS_OUT   = 'h00;
    localparam int OFS_DIR   = 'h04;
    localparam int OFS_BLINK = 'h08;
    localparam int OFS_POL   = 'h0C;
    localparam int OFS_DIN   = 'h10;
    localparam int OFS_CAUSE = 'h14;
    localparam int OFS_EMSK  = 'h18;
    localparam int OFS_LMSK  = 'h1C;
endpackage

// File: rtl/gpio_in_sync.sv
// Two-flop synchronizer for W asynchronous pad inputs, plus one extra
// stage that holds the previous synchronized level for edge detection.
// Assumes each pad bit is independent (no multi-bit coherence needed).
module gpio_in_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] cur,
    output logic [W-1:0] prv
);
    logic [W-1:0] meta_q;

    // Shift pad levels through the metastability stage and the history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            cur    <= '0;
            prv    <= '0;
        end else begin
            meta_q <= raw;
            cur    <= meta_q;
            prv    <= cur;
        end
    end
endmodule

// File: rtl/gpio_edge_latch.sv
// Sticky edge flags. A flag sets when the polarity-adjusted input goes
// 0 to 1. Both the current and the previous sample use the present
// polarity, so a polarity write alone never looks like an edge.
// A clearing write keeps bits written as 1, and a new edge beats a clear.
module gpio_edge_latch #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_cur,
    input  logic [W-1:0] lvl_prv,
    input  logic [W-1:0] pol,
    input  logic         clr_we,
    input  logic [W-1:0] keep,
    output logic [W-1:0] flags
);
    logic [W-1:0] rise;
    logic [W-1:0] kept;

    // Detect 0-to-1 of the visible input under the current polarity.
    always_comb rise = (lvl_cur ^ pol) & ~(lvl_prv ^ pol);

    // Apply the write-zero-to-clear mask when the flag register is written.
    always_comb kept = clr_we ? (flags & keep) : flags;

    // Update flags, with set taking priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= kept | rise;
    end
endmodule

// File: rtl/gpio_blink_gen.sv
// Shared blink phase: toggles once every DIV cycles, counted from reset.
// Assumes DIV >= 1.
module gpio_blink_gen #(
    parameter int DIV = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    output logic phase
);
    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    // Count cycles and flip the phase on each wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            phase <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
            phase <= ~phase;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/gpio_irq_bank.sv
// GPIO bank top. It holds the register file and decodes the bus,
// derives the input word and the pad drive, and ORs the per-pin
// requests into one summary line per bank of GROUP_W pins.
// Assumes NPINS is a multiple of GROUP_W, and that the shifted mask
// addresses do not collide with other registers.
module gpio_irq_bank
    import gpio_bank_pkg::*;
#(
    parameter int NPINS     = 32,
    parameter int GROUP_W   = 8,
    parameter int ADDR_W    = 8,
    parameter int MASK_OFS  = 0,
    parameter int BLINK_DIV = 1000000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_wr,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [NPINS-1:0]           bus_wdata,
    output logic [NPINS-1:0]           bus_rdata,
    input  logic [NPINS-1:0]           pad_in,
    output logic [NPINS-1:0]           pad_out,
    output logic [NPINS-1:0]           pad_oe,
    output logic [NPINS/GROUP_W-1:0]   irq_bank
);
    localparam int NGROUPS = NPINS / GROUP_W;
    localparam logic [ADDR_W-1:0] A_OUT   = ADDR_W'(OFS_OUT);
    localparam logic [ADDR_W-1:0] A_DIR   = ADDR_W'(OFS_DIR);
    localparam logic [ADDR_W-1:0] A_BLINK = ADDR_W'(OFS_BLINK);
    localparam logic [ADDR_W-1:0] A_POL   = ADDR_W'(OFS_POL);
    localparam logic [ADDR_W-1:0] A_DIN   = ADDR_W'(OFS_DIN);
    localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(OFS_CAUSE);
    localparam logic [ADDR_W-1:0] A_EMSK  = ADDR_W'(OFS_EMSK + MASK_OFS);
    localparam logic [ADDR_W-1:0] A_LMSK  = ADDR_W'(OFS_LMSK + MASK_OFS);

    logic [NPINS-1:0] out_q, dir_q, blink_q, pol_q, emask_q, lmask_q;
    logic [NPINS-1:0] sync_cur, sync_prv;
    logic [NPINS-1:0] data_in_w;
    logic [NPINS-1:0] edge_cause_w;
    logic [NPINS-1:0] pend_w;
    logic             cause_wr;
    logic             blink_phase;

    // Write the configuration registers from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q   <= '0;
            dir_q   <= '0;
            blink_q <= '0;
            pol_q   <= '0;
            emask_q <= '0;
            lmask_q <= '0;
        end else if (bus_wr) begin
            if (bus_addr == A_OUT)   out_q   <= bus_wdata;
            if (bus_addr == A_DIR)   dir_q   <= bus_wdata;
            if (bus_addr == A_BLINK) blink_q <= bus_wdata;
            if (bus_addr == A_POL)   pol_q   <= bus_wdata;
            if (bus_addr == A_EMSK)  emask_q <= bus_wdata;
            if (bus_addr == A_LMSK)  lmask_q <= bus_wdata;
        end
    end

    gpio_in_sync #(.W(NPINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (pad_in),
        .cur   (sync_cur),
        .prv   (sync_prv)
    );

    // Flag register writes that clear edge flags.
    always_comb cause_wr = bus_wr && (bus_addr == A_CAUSE);

    gpio_edge_latch #(.W(NPINS)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl_cur (sync_cur),
        .lvl_prv (sync_prv),
        .pol     (pol_q),
        .clr_we  (cause_wr),
        .keep    (bus_wdata),
        .flags   (edge_cause_w)
    );

    gpio_blink_gen #(.DIV(BLINK_DIV)) u_blink (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (blink_phase)
    );

    // Form the visible input word from the synchronized level and polarity.
    always_comb data_in_w = sync_cur ^ pol_q;

    // Drive pads: blink pins follow the phase, others their output bit.
    always_comb begin
        pad_out = (out_q & ~blink_q) | (blink_q & {NPINS{blink_phase}});
        pad_oe  = ~dir_q;
    end

    // Combine the per-pin level and edge requests.
    always_comb pend_w = (data_in_w & lmask_q) | (edge_cause_w & emask_q);

    for (genvar g = 0; g < NGROUPS; g++) begin : g_bank
        // OR one bank of pins onto its summary line.
        always_comb irq_bank[g] = |pend_w[g*GROUP_W +: GROUP_W];
    end

    // Return the addressed register; unmapped addresses read as zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_OUT)   bus_rdata = out_q;
        if (bus_addr == A_DIR)   bus_rdata = dir_q;
        if (bus_addr == A_BLINK) bus_rdata = blink_q;
        if (bus_addr == A_POL)   bus_rdata = pol_q;
        if (bus_addr == A_DIN)   bus_rdata = data_in_w;
        if (bus_addr == A_CAUSE) bus_rdata = edge_cause_w;
        if (bus_addr == A_EMSK)  bus_rdata = emask_q;
        if (bus_addr == A_LMSK)  bus_rdata = lmask_q;
    end
endmodule

// File: rtl/gpio_irq_bank_chk.sv
// Checker for the GPIO bank, bound into every instance of the top.
// Assumes it sees the register outputs and combined signals of the top.
module gpio_irq_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int NPINS     = 32,
    parameter int GROUP_W   = 8,
    parameter int ADDR_W    = 8,
    parameter int BLINK_DIV = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     bus_wr,
    input logic [ADDR_W-1:0]        bus_addr,
    input logic [NPINS-1:0]         data_in,
    input logic [NPINS-1:0]         lvl_mask,
    input logic [NPINS-1:0]         edge_mask,
    input logic [NPINS-1:0]         edge_cause,
    input logic [NPINS-1:0]         dir,
    input logic [NPINS-1:0]         out_val,
    input logic [NPINS-1:0]         pol,
    input logic [NPINS/GROUP_W-1:0] irq,
    input logic                     phase
);
    localparam int CW = (BLINK_DIV > 1) ? $clog2(BLINK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(BLINK_DIV - 1);
    localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(OFS_CAUSE);

    logic [CW-1:0] cyc_q;

    // Independent cycle counter marking the blink boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n)              cyc_q <= '0;
        else if (cyc_q == LAST)  cyc_q <= '0;
        else                     cyc_q <= cyc_q + 1'b1;
    end

    // R6 / R7: flags only drop on a write to the flag register.
    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == A_CAUSE) |=> (($past(edge_cause) & ~edge_cause) == '0));

    // R3: configuration holds without a bus write.
    assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ($stable(dir) && $stable(out_val) && $stable(pol)
                     && $stable(lvl_mask) && $stable(edge_mask)));

    // R5 / R9: an enabled level request reaches some summary line.
    assert_level_reaches_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((data_in & lvl_mask) != '0) |-> (irq != '0));

    // R9: an enabled edge flag reaches some summary line.
    assert_edge_reaches_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((edge_cause & edge_mask) != '0) |-> (irq != '0));

    // R9: no request anywhere means every summary line is low.
    assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (((data_in & lvl_mask) | (edge_cause & edge_mask)) == '0) |-> (irq == '0));

    // R10: the phase holds between boundaries.
    assert_phase_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q != LAST) |=> $stable(phase));

    // R10: the phase flips on each boundary.
    assert_phase_flip_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == LAST) |=> (phase != $past(phase)));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(
    .NPINS     (NPINS),
    .GROUP_W   (GROUP_W),
    .ADDR_W    (ADDR_W),
    .BLINK_DIV (BLINK_DIV)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .data_in    (data_in_w),
    .lvl_mask   (lmask_q),
    .edge_mask  (emask_q),
    .edge_cause (edge_cause_w),
    .dir        (dir_q),
    .out_val    (out_q),
    .pol        (pol_q),
    .irq        (irq_bank),
    .phase      (blink_phase)
);

// File: tb/gpio_irq_bank_tb.sv
// Bench: sweeps every pin through level and edge scenarios under both
// polarities, with a shifted mask window and a short blink divider.
module gpio_irq_bank_tb;
    localparam int N    = 32;
    localparam int AW   = 8;
    localparam int MOFS = 'h20;
    localparam int BDIV = 4;

    localparam logic [AW-1:0] A_OUT   = 8'h00;
    localparam logic [AW-1:0] A_DIR   = 8'h04;
    localparam logic [AW-1:0] A_BLINK = 8'h08;
    localparam logic [AW-1:0] A_POL   = 8'h0C;
    localparam logic [AW-1:0] A_DIN   = 8'h10;
    localparam logic [AW-1:0] A_CAUSE = 8'h14;
    localparam logic [AW-1:0] A_EMSK  = 8'h38;
    localparam logic [AW-1:0] A_LMSK  = 8'h3C;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [N-1:0]  bus_wdata = '0;
    logic [N-1:0]  bus_rdata;
    logic [N-1:0]  pad_in = '0;
    logic [N-1:0]  pad_out;
    logic [N-1:0]  pad_oe;
    logic [3:0]    irq_bank;

    int checks = 0;
    int bad    = 0;

    always #2 clk = ~clk;

    gpio_irq_bank #(
        .NPINS(N), .GROUP_W(8), .ADDR_W(AW), .MASK_OFS(MOFS), .BLINK_DIV(BDIV)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq_bank(irq_bank)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [N-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [N-1:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still summarises.
    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        logic [N-1:0] r;
        logic [N-1:0] bit_p;
        logic [N-1:0] idle;
        logic [3:0]   bank_exp;

        cyc(3);
        rst_n = 1'b1;

        // R1: reset state
        cyc(1);
        chk("R1 pad_oe", pad_oe, '1);
        chk("R1 pad_out", pad_out, '0);
        chk("R1 irq", {28'd0, irq_bank}, 32'd0);
        rd(A_OUT, r);   chk("R1 out", r, '0);
        rd(A_DIR, r);   chk("R1 dir", r, '0);
        rd(A_POL, r);   chk("R1 pol", r, '0);
        rd(A_CAUSE, r); chk("R1 cause", r, '0);
        rd(A_LMSK, r);  chk("R1 lmask", r, '0);

        // R2: direction and output value
        wr(A_OUT, 32'hA5A5_3C3C);
        wr(A_DIR, 32'hFFFF_0000);
        chk("R2 pad_oe", pad_oe, 32'h0000_FFFF);
        chk("R2 pad_out", pad_out, 32'hA5A5_3C3C);

        // R3: read-back, read-only input word, mask offset, unmapped
        wr(A_BLINK, 32'h0000_0000);
        wr(A_EMSK, 32'h1234_5678);
        wr(A_LMSK, 32'h0);
        rd(A_EMSK, r); chk("R3 emask readback", r, 32'h1234_5678);
        wr(8'h18, 32'hFFFF_FFFF);
        rd(A_EMSK, r); chk("R3 nominal emask addr ignored", r, 32'h1234_5678);
        wr(8'h1C, 32'hFFFF_FFFF);
        rd(A_LMSK, r); chk("R3 nominal lmask addr ignored", r, 32'h0);
        rd(8'h1C, r);  chk("R3 unmapped read", r, 32'h0);
        wr(A_DIN, 32'hFFFF_FFFF);
        rd(A_DIN, r);  chk("R3 input word read-only", r, 32'h0);
        wr(8'h40, 32'hFFFF_FFFF);
        rd(A_OUT, r);  chk("R3 unmapped write ignored", r, 32'hA5A5_3C3C);
        wr(A_EMSK, 32'h0);
        wr(A_DIR, 32'hFFFF_FFFF);
        wr(A_OUT, 32'h0);

        // R4: two-cycle synchronizer latency and polarity inversion
        @(negedge clk); pad_in = 32'h0000_0100;
        cyc(1); rd(A_DIN, r);
        chk("R4 visible after two edges", r, 32'h0000_0100);
        @(negedge clk); pad_in = 32'h0;
        cyc(1);
        bus_addr = A_DIN; #1 chk("R4 not visible after one edge", bus_rdata, 32'h0000_0100);
        cyc(1);
        bus_addr = A_DIN; #1 chk("R4 cleared after two edges", bus_rdata, 32'h0);
        wr(A_POL, 32'h0000_0003);
        rd(A_DIN, r); chk("R4 polarity inverts", r, 32'h0000_0003);
        wr(A_POL, 32'h0);
        wr(A_CAUSE, 32'h0);

        // R5 / R9: level sweep over every pin
        for (int p = 0; p < N; p++) begin
            bit_p = 32'd1 << p;
            bank_exp = 4'd1 << (p / 8);
            wr(A_LMSK, bit_p);
            @(negedge clk); pad_in = bit_p;
            cyc(2);
            chk($sformatf("R9 level bank pin %0d", p), {28'd0, irq_bank}, {28'd0, bank_exp});
            rd(A_DIN, r); chk($sformatf("R4 pin %0d", p), r, bit_p);
            wr(A_LMSK, bit_p ^ 32'hFFFF_FFFF);
            chk($sformatf("R5 masked pin %0d", p), {28'd0, irq_bank}, 32'd0);
            wr(A_LMSK, bit_p);
            @(negedge clk); pad_in = '0;
            cyc(2);
            chk($sformatf("R5 no latch pin %0d", p), {28'd0, irq_bank}, 32'd0);
        end
        wr(A_LMSK, 32'h0);

        // R6 / R7 / R8: edge sweep over every pin and both polarities
        for (int p = 0; p < N; p++) begin
            for (int pl = 0; pl < 2; pl++) begin
                bit_p = 32'd1 << p;
                bank_exp = 4'd1 << (p / 8);
                idle = (pl != 0) ? bit_p : 32'h0;
                wr(A_EMSK, bit_p);
                wr(A_CAUSE, 32'h0);
                wr(A_POL, idle);
                @(negedge clk); pad_in = idle;
                cyc(4);
                rd(A_CAUSE, r);
                chk($sformatf("R8 no flag from polarity pin %0d pol %0d", p, pl), r, 32'h0);
                @(negedge clk); pad_in = idle ^ bit_p;
                cyc(3);
                rd(A_CAUSE, r);
                chk($sformatf("R6 flag set pin %0d pol %0d", p, pl), r, bit_p);
                chk($sformatf("R9 edge bank pin %0d", p), {28'd0, irq_bank}, {28'd0, bank_exp});
                @(negedge clk); pad_in = idle;
                cyc(4);
                rd(A_CAUSE, r);
                chk($sformatf("R6 sticky pin %0d pol %0d", p, pl), r, bit_p);
                wr(A_CAUSE, 32'hFFFF_FFFF);
                rd(A_CAUSE, r);
                chk($sformatf("R7 one keeps pin %0d", p), r, bit_p);
                wr(A_CAUSE, bit_p ^ 32'hFFFF_FFFF);
                rd(A_CAUSE, r);
                chk($sformatf("R7 zero clears pin %0d", p), r, 32'h0);
                chk($sformatf("R9 cleared pin %0d", p), {28'd0, irq_bank}, 32'd0);
            end
        end
        wr(A_POL, 32'h0);
        @(negedge clk); pad_in = '0;
        cyc(4);
        wr(A_CAUSE, 32'h0);

        // R7: set wins over a concurrent clear
        @(negedge clk); pad_in = 32'h0000_0001;
        cyc(3);
        rd(A_CAUSE, r); chk("R7 setup flag", r, 32'h0000_0001);
        @(negedge clk); pad_in = 32'h0000_0011;
        @(negedge clk);
        wr(A_CAUSE, 32'h0);
        rd(A_CAUSE, r); chk("R7 set beats clear", r, 32'h0000_0010);

        // R10: blink phase on pin 3, pin 5 holds its value
        wr(A_DIR, 32'h0);
        wr(A_OUT, 32'h0000_0028);
        wr(A_BLINK, 32'h0000_0008);
        begin
            logic prev;
            int last_t;
            int toggles;
            last_t = -1;
            toggles = 0;
            @(negedge clk); prev = pad_out[3];
            for (int t = 0; t < 40; t++) begin
                @(negedge clk);
                if (pad_out[3] != prev) begin
                    if (last_t >= 0)
                        chk("R10 blink interval", t - last_t, BDIV);
                    last_t = t;
                    toggles++;
                    prev = pad_out[3];
                end
            end
            chk("R10 toggle count", (toggles >= 9) ? 1 : 0, 1);
            chk("R10 steady pin", {31'd0, pad_out[5]}, 32'd1);
        end
        wr(A_BLINK, 32'h0);
        chk("R10 blink off returns to value", pad_out, 32'h0000_0028);

        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule